// File: doc/BRIEF.md
# Class-D Bridge Mode and Fault Controller

This block is the digital control core of a two-channel bridge-tied-load switching amplifier output stage. Each channel has two output nodes. Each node is built from a high-side and a low-side transistor, and the block drives one enable per transistor. Each channel receives a pair of PWM logic inputs, one per node. The block decides, on every clock, whether each node is floating, pulled to ground or pulled to the supply. Two active-low control pins set the operating mode: a sleep pin and a quiet pin. A turn-on delay counted in clock cycles separates release of the quiet pin from the first switching of the bridge.

Protection inputs arrive already digitised:
- an unsigned die-temperature code in degrees;
- one overcurrent flag per channel;
- a good flag for the power rail;
- a good flag for the logic rail.

A hot die raises a warning flag. The warning has hysteresis and does not stop the bridge. An overheated die, an overcurrent or a power-rail undervoltage raises a latched error and floats every node. The error is released only by a fall and rise of the quiet pin made after the cause has gone. Both flags leave the block as open-drain pull-down enables.

All inputs are taken to be synchronous to `clk`. The bridge turns on `TURNON_CYC + 2` clock edges after the quiet pin is sampled high. With a 200 MHz clock, the default of 40000 cycles gives about 200 µs.

Top module: `cdamp_bridge_ctrl`

## Requirements
- R1: After reset, and from the first clock edge at which `shdn_n` is sampled low, all eight gate enables are 0. `warn_od` and `err_od` reset to 0.
- R2: With `shdn_n` high and `mute_n` low, all gate enables are 0 from the next edge, whatever the PWM inputs are.
- R3: When running, each node follows its own PWM bit. Input 1 gives high-side on and low-side off (node at supply). Input 0 gives low-side on and high-side off (node at ground). So input pair 00 damps both nodes to ground, 10 drives positive, 01 drives negative, and 11 puts both nodes at supply.
- R4: Once `shdn_n`, `dvdd_ok` and `pvdd_ok` are high and no error is latched, the gate enables stay 0 for `TURNON_CYC + 1` edges after `mute_n` is first sampled high. They follow R3 from edge `TURNON_CYC + 2` onward.
- R5: On a node, the high-side and low-side enables are never both 1. When a node changes from one transistor to the other, both are 0 for exactly `DEAD_CYC + 1` cycles.
- R6: `warn_od` becomes 1 one edge after `die_temp >= WARN_ON`. It becomes 0 one edge after `die_temp <= WARN_OFF`. Between the two thresholds it holds its value. The warning alone does not change the gate enables.
- R7: One edge after `die_temp > TRIP_TEMP`, `err_od` is 1 and all gate enables are 0. A temperature equal to `TRIP_TEMP` does not trip.
- R8: One edge after any bit of `ocp` is 1, `err_od` is 1 and all gate enables are 0.
- R9: A low `pvdd_ok` acts like R8. A low `dvdd_ok` forces all gate enables to 0 from the next edge without setting `err_od`. When `dvdd_ok` returns, turn-on follows R4.
- R10: Once set, `err_od` stays 1, and the gates stay 0, until a rising edge of `mute_n` is sampled. This holds even after the cause has gone.
- R11: A `mute_n` rising edge sampled while any fault cause is still present does not clear `err_od`. A rising edge with no cause present clears it at that edge.
- R12: `warn_od` and `err_od` are open-drain pull-down enables: 1 means the shared active-low flag line is pulled low (flag asserted).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_n | input | 1 | Active-low sleep request |
| mute_n | input | 1 | Active-low quiet request; a low-to-high toggle releases a latched error |
| pwm_p | input | NCH | PWM bit for the positive node of each channel |
| pwm_m | input | NCH | PWM bit for the negative node of each channel |
| die_temp | input | TEMP_W | Die temperature code, degrees, unsigned |
| ocp | input | NCH | Per-channel overcurrent flag |
| pvdd_ok | input | 1 | Power rail above its threshold |
| dvdd_ok | input | 1 | Logic rail above its threshold |
| hs_p | output | NCH | High-side enable, positive node |
| ls_p | output | NCH | Low-side enable, positive node |
| hs_m | output | NCH | High-side enable, negative node |
| ls_m | output | NCH | Low-side enable, negative node |
| warn_od | output | 1 | Pull-down enable for the thermal warning line |
| err_od | output | 1 | Pull-down enable for the error line |

## Verification
The bound checker watches, on every cycle, the properties that can be stated as properties:
- no shoot-through on any node, and at least the required dead gap before any transistor turns on again;
- forced-off gates one edge after sleep, quiet, logic-rail loss or any fault cause;
- error set on each fault cause;
- error held while no quiet-pin rise arrives, or while a cause persists;
- both warning thresholds.

Some behaviour only the directed scenarios can show:
- the exact turn-on edge after the delay;
- the per-node decode of every PWM pattern;
- the exact length of the dead gap;
- the temperature band where the warning holds;
- the boundary at exactly the trip temperature;
- that a toggle made during a persisting fault leaves the error set until a later clean toggle.

// File: rtl/cdamp_pkg.sv
package cdamp_pkg;

  // Drive state requested for one output node
  typedef enum logic [1:0] {
    NODE_OFF = 2'd0,
    NODE_GND = 2'd1,
    NODE_SUP = 2'd2
  } node_t;

  // Operating mode of the bridge
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_STBY  = 2'd1,
    MODE_WAIT  = 2'd2,
    MODE_RUN   = 2'd3
  } mode_t;

  // A live node follows its PWM bit; a dead node floats
  function automatic node_t node_from_pwm(input logic live, input logic lvl);
    if (!live) return NODE_OFF;
    return lvl ? NODE_SUP : NODE_GND;
  endfunction

  // Two-threshold hysteresis: set on hot, clear on cool, hold otherwise
  function automatic logic hyst_next(input logic cur, input logic hot, input logic cool);
    if (hot) return 1'b1;
    if (cool) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/cdamp_thermal.sv
module cdamp_thermal #(
  parameter int TEMP_W    = 8,
  parameter int WARN_ON   = 135,
  parameter int WARN_OFF  = 120,
  parameter int TRIP_TEMP = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] die_temp,
  output logic              warn_q,
  output logic              over_trip
);
  localparam logic [TEMP_W-1:0] ON_CODE   = TEMP_W'(WARN_ON);
  localparam logic [TEMP_W-1:0] OFF_CODE  = TEMP_W'(WARN_OFF);
  localparam logic [TEMP_W-1:0] TRIP_CODE = TEMP_W'(TRIP_TEMP);

  logic hot, cool;
  assign hot       = (die_temp >= ON_CODE);
  assign cool      = (die_temp <= OFF_CODE);
  assign over_trip = (die_temp > TRIP_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warn_q <= 1'b0;
    else        warn_q <= cdamp_pkg::hyst_next(warn_q, hot, cool);
  end
endmodule

// File: rtl/cdamp_fault_latch.sv
module cdamp_fault_latch #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mute_n,
  input  logic [NCH-1:0] ocp,
  input  logic           pvdd_ok,
  input  logic           over_trip,
  output logic           fault_src,
  output logic           mute_rise,
  output logic           err_q
);
  logic mute_q;

  assign fault_src = (|ocp) | ~pvdd_ok | over_trip;
  assign mute_rise = mute_n & ~mute_q;

  // A cause present at the edge always wins over the release toggle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      mute_q <= mute_n;
      if (fault_src)      err_q <= 1'b1;
      else if (mute_rise) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cdamp_mode_fsm.sv
module cdamp_mode_fsm
  import cdamp_pkg::*;
#(
  parameter int TURNON_CYC = 40000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shdn_n,
  input  logic  mute_n,
  input  logic  dvdd_ok,
  input  logic  fault_src,
  input  logic  err_q,
  output mode_t mode_q,
  output logic  bridge_live
);
  localparam int CNT_W = $clog2(TURNON_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TURNON_CYC - 1);

  mode_t           mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic            hold_off;

  assign hold_off = ~mute_n | ~dvdd_ok | fault_src | err_q;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (!shdn_n) begin
      mode_d = MODE_SLEEP;
    end else begin
      unique case (mode_q)
        MODE_SLEEP: mode_d = MODE_STBY;
        MODE_STBY: if (!hold_off) begin
          mode_d = MODE_WAIT;
          cnt_d  = '0;
        end
        MODE_WAIT: begin
          if (hold_off)           mode_d = MODE_STBY;
          else if (cnt_q == LAST) mode_d = MODE_RUN;
          else                    cnt_d  = cnt_q + 1'b1;
        end
        MODE_RUN: if (hold_off) mode_d = MODE_STBY;
        default: mode_d = MODE_SLEEP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_SLEEP;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  // Any stop condition floats the nodes in the same cycle it is seen
  assign bridge_live = (mode_q == MODE_RUN) & shdn_n & ~hold_off;
endmodule

// File: rtl/cdamp_node_drv.sv
module cdamp_node_drv
  import cdamp_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  node_t target,
  output logic  hs_en,
  output logic  ls_en
);
  localparam int DW = $clog2(DEAD_CYC + 2);
  localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD_CYC);

  logic          want_hs, want_ls;
  logic          hs_d, ls_d;
  logic [DW-1:0] gap_q, gap_d;

  assign want_hs = (target == NODE_SUP);
  assign want_ls = (target == NODE_GND);

  // Turn-off is immediate and restarts the gap; turn-on waits for an idle node
  always_comb begin
    hs_d  = hs_en;
    ls_d  = ls_en;
    gap_d = (gap_q == '0) ? '0 : gap_q - 1'b1;
    if (hs_en && !want_hs) begin
      hs_d  = 1'b0;
      gap_d = DEAD_LOAD;
    end
    if (ls_en && !want_ls) begin
      ls_d  = 1'b0;
      gap_d = DEAD_LOAD;
    end
    if (want_hs && !hs_en && !ls_en && gap_q == '0) hs_d = 1'b1;
    if (want_ls && !ls_en && !hs_en && gap_q == '0) ls_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_en <= 1'b0;
      ls_en <= 1'b0;
      gap_q <= '0;
    end else begin
      hs_en <= hs_d;
      ls_en <= ls_d;
      gap_q <= gap_d;
    end
  end
endmodule

// File: rtl/cdamp_bridge_ctrl.sv
module cdamp_bridge_ctrl
  import cdamp_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int TEMP_W     = 8,
  parameter int WARN_ON    = 135,
  parameter int WARN_OFF   = 120,
  parameter int TRIP_TEMP  = 150,
  parameter int TURNON_CYC = 40000,
  parameter int DEAD_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shdn_n,
  input  logic              mute_n,
  input  logic [NCH-1:0]    pwm_p,
  input  logic [NCH-1:0]    pwm_m,
  input  logic [TEMP_W-1:0] die_temp,
  input  logic [NCH-1:0]    ocp,
  input  logic              pvdd_ok,
  input  logic              dvdd_ok,
  output logic [NCH-1:0]    hs_p,
  output logic [NCH-1:0]    ls_p,
  output logic [NCH-1:0]    hs_m,
  output logic [NCH-1:0]    ls_m,
  output logic              warn_od,
  output logic              err_od
);
  // Internal events, named for the checker and for waveform reading
  logic  warn_q, over_trip;
  logic  fault_src, mute_rise, err_q;
  logic  bridge_live;
  mode_t mode_q;

  cdamp_thermal #(
    .TEMP_W(TEMP_W), .WARN_ON(WARN_ON), .WARN_OFF(WARN_OFF), .TRIP_TEMP(TRIP_TEMP)
  ) u_thermal (
    .clk(clk), .rst_n(rst_n), .die_temp(die_temp),
    .warn_q(warn_q), .over_trip(over_trip)
  );

  cdamp_fault_latch #(.NCH(NCH)) u_fault (
    .clk(clk), .rst_n(rst_n), .mute_n(mute_n), .ocp(ocp), .pvdd_ok(pvdd_ok),
    .over_trip(over_trip), .fault_src(fault_src), .mute_rise(mute_rise), .err_q(err_q)
  );

  cdamp_mode_fsm #(.TURNON_CYC(TURNON_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .mute_n(mute_n), .dvdd_ok(dvdd_ok),
    .fault_src(fault_src), .err_q(err_q), .mode_q(mode_q), .bridge_live(bridge_live)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    node_t tgt_p, tgt_m;
    assign tgt_p = node_from_pwm(bridge_live, pwm_p[c]);
    assign tgt_m = node_from_pwm(bridge_live, pwm_m[c]);

    cdamp_node_drv #(.DEAD_CYC(DEAD_CYC)) u_node_p (
      .clk(clk), .rst_n(rst_n), .target(tgt_p), .hs_en(hs_p[c]), .ls_en(ls_p[c])
    );
    cdamp_node_drv #(.DEAD_CYC(DEAD_CYC)) u_node_m (
      .clk(clk), .rst_n(rst_n), .target(tgt_m), .hs_en(hs_m[c]), .ls_en(ls_m[c])
    );
  end

  assign warn_od = warn_q;
  assign err_od  = err_q;
endmodule

// File: rtl/cdamp_bridge_chk.sv
module cdamp_bridge_chk #(
  parameter int NCH       = 2,
  parameter int TEMP_W    = 8,
  parameter int WARN_ON   = 135,
  parameter int WARN_OFF  = 120,
  parameter int TRIP_TEMP = 150,
  parameter int DEAD_CYC  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shdn_n,
  input logic              mute_n,
  input logic [TEMP_W-1:0] die_temp,
  input logic [NCH-1:0]    ocp,
  input logic              pvdd_ok,
  input logic              dvdd_ok,
  input logic [NCH-1:0]    hs_p,
  input logic [NCH-1:0]    ls_p,
  input logic [NCH-1:0]    hs_m,
  input logic [NCH-1:0]    ls_m,
  input logic              warn_od,
  input logic              err_od
);
  localparam int NN = 2 * NCH;
  localparam int GW = $clog2(DEAD_CYC + 2) + 1;
  localparam logic [GW-1:0] GMAX = GW'(DEAD_CYC + 1);

  logic [NN-1:0] hs_all, ls_all;
  logic          all_off, cause;

  assign hs_all  = {hs_p, hs_m};
  assign ls_all  = {ls_p, ls_m};
  assign all_off = ((hs_all | ls_all) == '0);
  assign cause   = (ocp != '0) || !pvdd_ok || (die_temp > TEMP_W'(TRIP_TEMP));

  assert_no_shoot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_all & ls_all) == '0);

  for (genvar i = 0; i < NN; i++) begin : g_gap
    logic [GW-1:0] idle_q;
    logic          seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idle_q <= '0;
        seen_q <= 1'b0;
      end else if (hs_all[i] || ls_all[i]) begin
        idle_q <= '0;
        seen_q <= 1'b1;
      end else if (idle_q != GMAX) begin
        idle_q <= idle_q + 1'b1;
      end
    end
    assert_dead_hs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hs_all[i]) && seen_q) |-> (idle_q >= GMAX));
    assert_dead_ls_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ls_all[i]) && seen_q) |-> (idle_q >= GMAX));
  end

  assert_sleep_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |=> all_off);
  assert_quiet_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_n |=> all_off);
  assert_logic_rail_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !dvdd_ok |=> all_off);
  assert_hot_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (die_temp > TEMP_W'(TRIP_TEMP)) |=> (err_od && all_off));
  assert_overcurrent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp != '0) |=> (err_od && all_off));
  assert_power_rail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pvdd_ok |=> (err_od && all_off));
  assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_od && !$rose(mute_n)) |=> (err_od && all_off));
  assert_err_stuck_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_od && cause) |=> err_od);
  assert_warn_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (die_temp >= TEMP_W'(WARN_ON)) |=> warn_od);
  assert_warn_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (die_temp <= TEMP_W'(WARN_OFF)) |=> !warn_od);
endmodule

bind cdamp_bridge_ctrl cdamp_bridge_chk #(
  .NCH(NCH), .TEMP_W(TEMP_W), .WARN_ON(WARN_ON), .WARN_OFF(WARN_OFF),
  .TRIP_TEMP(TRIP_TEMP), .DEAD_CYC(DEAD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .mute_n(mute_n), .die_temp(die_temp),
  .ocp(ocp), .pvdd_ok(pvdd_ok), .dvdd_ok(dvdd_ok), .hs_p(hs_p), .ls_p(ls_p),
  .hs_m(hs_m), .ls_m(ls_m), .warn_od(warn_od), .err_od(err_od)
);

// File: tb/cdamp_bridge_ctrl_bench.sv
module cdamp_bridge_ctrl_bench;
  localparam int NCH = 2;
  localparam int TW  = 8;
  localparam int T   = 16;
  localparam int D   = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          shdn_n = 1'b0, mute_n = 1'b0;
  logic [NCH-1:0] pwm_p = '0, pwm_m = '0, ocp = '0;
  logic [TW-1:0] die_temp = 8'd25;
  logic          pvdd_ok = 1'b1, dvdd_ok = 1'b1;
  logic [NCH-1:0] hs_p, ls_p, hs_m, ls_m;
  logic          warn_od, err_od;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cdamp_bridge_ctrl #(
    .NCH(NCH), .TEMP_W(TW), .WARN_ON(135), .WARN_OFF(120), .TRIP_TEMP(150),
    .TURNON_CYC(T), .DEAD_CYC(D)
  ) u_cdamp_bridge_ctrl (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .mute_n(mute_n), .pwm_p(pwm_p),
    .pwm_m(pwm_m), .die_temp(die_temp), .ocp(ocp), .pvdd_ok(pvdd_ok),
    .dvdd_ok(dvdd_ok), .hs_p(hs_p), .ls_p(ls_p), .hs_m(hs_m), .ls_m(ls_m),
    .warn_od(warn_od), .err_od(err_od)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] gates();
    return 32'({hs_p, ls_p, hs_m, ls_m});
  endfunction

  // Running-node expectation: bit 1 -> high side, bit 0 -> low side
  function automatic logic [31:0] run_exp(input logic [NCH-1:0] p, input logic [NCH-1:0] m);
    return 32'({p, ~p, m, ~m});
  endfunction

  task automatic toggle_quiet();
    mute_n = 1'b0; tick(2);
    mute_n = 1'b1; tick(1);
  endtask

  task automatic t_reset();
    chk("R1 reset gates", gates(), 0);
    chk("R12 reset warn", 32'(warn_od), 0);
    chk("R12 reset err", 32'(err_od), 0);
  endtask

  task automatic t_standby();
    pwm_p = 2'b01; pwm_m = 2'b10; tick(3);
    chk("R1 sleep gates", gates(), 0);
    shdn_n = 1'b1; tick(T + 6);
    chk("R2 quiet gates", gates(), 0);
    pwm_p = 2'b11; pwm_m = 2'b11; tick(4);
    chk("R2 quiet ignores pwm", gates(), 0);
    pwm_p = '0; pwm_m = '0; tick(2);
  endtask

  task automatic t_turnon();
    mute_n = 1'b1;
    tick(T + 1);
    chk("R4 still off at T+1", gates(), 0);
    tick(1);
    chk("R4 on at T+2", gates(), run_exp('0, '0));
  endtask

  task automatic t_decode();
    pwm_p = 2'b01; pwm_m = 2'b00; tick(D + 4);
    chk("R3 ch0 positive ch1 damped", gates(), run_exp(pwm_p, pwm_m));
    pwm_p = 2'b10; pwm_m = 2'b01; tick(D + 4);
    chk("R3 ch0 negative ch1 positive", gates(), run_exp(pwm_p, pwm_m));
    pwm_p = 2'b11; pwm_m = 2'b11; tick(D + 4);
    chk("R3 both at supply", gates(), run_exp(pwm_p, pwm_m));
    pwm_p = 2'b00; pwm_m = 2'b10; tick(D + 4);
    chk("R3 ch1 negative", gates(), run_exp(pwm_p, pwm_m));
    pwm_p = '0; pwm_m = '0; tick(D + 4);
  endtask

  task automatic t_quiet_running();
    pwm_p = 2'b01; tick(D + 4);
    mute_n = 1'b0; tick(1);
    chk("R2 quiet forces off", gates(), 0);
    pwm_m = 2'b11; tick(3);
    chk("R2 quiet holds off", gates(), 0);
    pwm_p = '0; pwm_m = '0;
    mute_n = 1'b1; tick(T + 4);
    chk("R4 rerun damped", gates(), run_exp('0, '0));
  endtask

  task automatic t_deadtime();
    int gap = 0;
    pwm_p[0] = 1'b1; tick(1);
    while (hs_p[0] == 1'b0 && ls_p[0] == 1'b0 && gap < 40) begin gap++; tick(1); end
    chk("R5 gap to high side", 32'(gap), 32'(D + 1));
    chk("R5 high side on", 32'({hs_p[0], ls_p[0]}), 32'b10);
    gap = 0;
    pwm_p[0] = 1'b0; tick(1);
    while (hs_p[0] == 1'b0 && ls_p[0] == 1'b0 && gap < 40) begin gap++; tick(1); end
    chk("R5 gap to low side", 32'(gap), 32'(D + 1));
    chk("R5 low side on", 32'({hs_p[0], ls_p[0]}), 32'b01);
  endtask

  task automatic t_warning();
    die_temp = 8'd134; tick(1);
    chk("R6 below set", 32'(warn_od), 0);
    die_temp = 8'd135; tick(1);
    chk("R6 set at threshold", 32'(warn_od), 1);
    chk("R6 bridge keeps running", gates(), run_exp('0, '0));
    die_temp = 8'd121; tick(2);
    chk("R6 holds in band", 32'(warn_od), 1);
    die_temp = 8'd120; tick(1);
    chk("R6 clears at low threshold", 32'(warn_od), 0);
    die_temp = 8'd130; tick(2);
    chk("R6 stays clear in band", 32'(warn_od), 0);
    die_temp = 8'd25; tick(1);
  endtask

  task automatic t_overtemp();
    die_temp = 8'd150; tick(1);
    chk("R7 equal does not trip", 32'(err_od), 0);
    chk("R7 equal keeps gates", gates(), run_exp('0, '0));
    die_temp = 8'd151; tick(1);
    chk("R7 trip err", 32'(err_od), 1);
    chk("R7 trip gates", gates(), 0);
    die_temp = 8'd25; tick(4);
    chk("R10 held after cool", 32'(err_od), 1);
    toggle_quiet();
    chk("R11 clean toggle clears", 32'(err_od), 0);
    tick(T + 4);
    chk("R4 resume after release", gates(), run_exp('0, '0));
  endtask

  task automatic t_overcurrent_hold();
    ocp = 2'b10; tick(1);
    chk("R8 err on ch1 overcurrent", 32'(err_od), 1);
    chk("R8 gates off", gates(), 0);
    ocp = '0; tick(10);
    chk("R10 latched with quiet high", 32'(err_od), 1);
    chk("R10 gates stay off", gates(), 0);
    toggle_quiet();
    chk("R11 release", 32'(err_od), 0);
    tick(T + 4);
  endtask

  task automatic t_toggle_during_fault();
    ocp = 2'b01; tick(1);
    chk("R8 err on ch0 overcurrent", 32'(err_od), 1);
    toggle_quiet();
    chk("R11 toggle with cause keeps err", 32'(err_od), 1);
    tick(T + 4);
    chk("R11 gates stay off", gates(), 0);
    ocp = '0; tick(3);
    chk("R11 still latched after cause gone", 32'(err_od), 1);
    toggle_quiet();
    chk("R11 later clean toggle clears", 32'(err_od), 0);
    tick(T + 4);
    chk("R11 resumes", gates(), run_exp('0, '0));
  endtask

  task automatic t_rails();
    pvdd_ok = 1'b0; tick(1);
    chk("R9 power rail err", 32'(err_od), 1);
    chk("R9 power rail gates", gates(), 0);
    pvdd_ok = 1'b1; tick(2);
    toggle_quiet();
    chk("R9 power rail release", 32'(err_od), 0);
    tick(T + 4);
    dvdd_ok = 1'b0; tick(1);
    chk("R9 logic rail gates", gates(), 0);
    tick(5);
    chk("R9 logic rail no err", 32'(err_od), 0);
    chk("R9 logic rail blocks turn-on", gates(), 0);
    dvdd_ok = 1'b1;
    tick(T + 1);
    chk("R4 logic rail return still off", gates(), 0);
    tick(1);
    chk("R4 logic rail return on", gates(), run_exp('0, '0));
  endtask

  task automatic t_sleep();
    pwm_p = 2'b11; tick(D + 4);
    shdn_n = 1'b0; tick(1);
    chk("R1 sleep forces off", gates(), 0);
    chk("R12 flags idle in sleep", 32'({warn_od, err_od}), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    tick(4);
    t_reset();
    rst_n = 1'b1; tick(2);
    t_reset();
    t_standby();
    t_turnon();
    t_decode();
    t_quiet_running();
    t_deadtime();
    t_warning();
    t_overtemp();
    t_overcurrent_hold();
    t_toggle_during_fault();
    t_rails();
    t_sleep();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end
endmodule